// File: doc/BRIEF.md
# Two-Wire Serial Memory Write Slave

This block is the write side of a two-wire serial memory slave. It watches the clock and data lines. It detects start and stop conditions and shifts in bytes most significant bit first. After every eighth bit it decides whether to pull the data line low on the ninth clock. A write frame has four parts, in this order: a command byte, an identity byte that must equal the locally configured identity, a word address, and one or more data bytes. The data bytes collect in a page buffer. A stop condition then copies them into a behavioural memory array and starts a timed internal write cycle.

A second command value programs a one-time protect bit. After it is set, the array can no longer be changed. A low-supply input turns off all array and protect-bit programming. The word address selects a page, given by its upper bits, and a start offset inside that page, given by its lower bits. The offset advances and wraps within the page, so more bytes than the page holds overwrite the earlier ones.

The array can be read through a plain combinational lookup port so that its contents can be observed. The output-enable bit of the last accepted command byte is presented on a pin. The clock and data inputs are assumed to be slow compared with the system clock.

Top module: `eewr_slave`

## Requirements
- R1: After reset the data line is released, no write cycle is running, the protect bit is clear and the output-enable pin is low.
- R2: A command byte with bits [7:4]=0110 and bits [2:0]=010 is a write command. It is acknowledged by driving the data line low during the ninth clock, while the clock is low or high, and its bit 3 is copied to `out_en_o`. A byte with any other value in those bits, other than the protect command, gets no acknowledge.
- R3: The identity byte is acknowledged only when it equals `local_id_i`. Otherwise that byte and every later byte of the frame get no acknowledge, and the stop starts no write cycle.
- R4: A write frame with a word address, one data byte and a stop sets the array location at that address to the data byte once the write cycle ends.
- R5: Data bytes of one frame go to consecutive offsets of the page named by address bits [7:4], starting at offset bits [3:0]. The offset wraps from 15 to 0, and a later byte replaces an earlier byte at the same offset.
- R6: A stop that ends a frame with at least one acknowledged data byte starts a write cycle. `busy_o` then stays high for exactly WRITE_CYCLES clocks, and no byte of any kind is acknowledged while it is high.
- R7: A protect command (bits [7:4]=0110, bits [2:0]=000) with a matching identity, an address byte and a data byte, all of whose values are ignored, followed by a stop sets `lock_o` for good. From then on, write frames are acknowledged but leave the array unchanged.
- R8: While `lock_o` is set, the protect command byte and the rest of its frame get no acknowledge, and no write cycle starts.
- R9: While `low_supply_i` is high, a write frame is acknowledged and its write cycle runs, but the array and the protect bit stay unchanged.
- R10: A start or stop condition resets the bit shifter and the frame sequencer. A repeated start in the middle of a frame begins a fresh frame, and a frame stopped before any data byte starts no write cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen by the slave |
| sda_i | input | 1 | Serial data line as seen by the slave |
| sda_oe_o | output | 1 | High while the slave pulls the data line low (acknowledge) |
| local_id_i | input | 8 | Identity value the identity byte must match |
| low_supply_i | input | 1 | Low-supply flag; blocks all programming |
| out_en_o | output | 1 | Output-enable bit from the last accepted command byte |
| busy_o | output | 1 | Internal write cycle in progress |
| lock_o | output | 1 | One-time protect bit |
| rd_addr_i | input | $clog2(MEM_BYTES) | Array lookup address |
| rd_data_o | output | 8 | Array contents at `rd_addr_i` |

## Verification
The case hardest to reach is a byte that arrives while the internal write cycle is still running. The cycle only starts after a stop, and it has to outlast a start condition plus nine bus clocks. The bench therefore sets WRITE_CYCLES well above the length of one byte. It issues a new start immediately after the committing stop and checks that the command byte gets no acknowledge. Page wrap-around needs a frame longer than the page, starting from a nonzero offset. The expected page contents are rebuilt in the bench by replaying the bytes in order onto wrapped offsets.

// File: rtl/eewr_pkg.sv
// Shared types and constants for the two-wire write slave.
// Assumes byte-wide word addresses (array of at most 256 bytes).
package eewr_pkg;
    typedef enum logic [2:0] {
        FR_IDLE,
        FR_CTRL,
        FR_ID,
        FR_ADDR,
        FR_DATA,
        FR_SKIP
    } frame_st_t;

    localparam logic [3:0] CMD_TAG    = 4'b0110;
    localparam logic [2:0] LOW_WRITE  = 3'b010;
    localparam logic [2:0] LOW_LOCK   = 3'b000;
endpackage

// File: rtl/eewr_bus.sv
// Bit-level front end: samples SCL/SDA, detects start/stop, shifts bytes
// in MSB first and drives the ninth-clock acknowledge.
// Assumes SCL and SDA change slowly relative to clk (several clocks per phase).
module eewr_bus (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       ack_en,
    output logic       start_p,
    output logic       stop_p,
    output logic       byte_p,
    output logic [7:0] byte_q,
    output logic       sda_oe_o
);
    logic       scl_s, scl_d, sda_s, sda_d;
    logic       active, in_ack, ack_lat;
    logic [3:0] bit_cnt;
    logic [7:0] shreg;
    logic       scl_rise, scl_fall;

    // Register the bus lines and keep their previous sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_s <= 1'b1; scl_d <= 1'b1;
            sda_s <= 1'b1; sda_d <= 1'b1;
        end else begin
            scl_s <= scl_i; scl_d <= scl_s;
            sda_s <= sda_i; sda_d <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_d;
    assign scl_fall = ~scl_s & scl_d;
    assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;
    assign byte_q   = {shreg[6:0], sda_s};
    assign byte_p   = active & scl_rise & (bit_cnt == 4'd7);

    // Shift bits, time the acknowledge slot and restart on start/stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0; in_ack <= 1'b0; ack_lat <= 1'b0;
            bit_cnt <= '0; shreg <= '0; sda_oe_o <= 1'b0;
        end else if (start_p || stop_p) begin
            active <= start_p; in_ack <= 1'b0; ack_lat <= 1'b0;
            bit_cnt <= '0; sda_oe_o <= 1'b0;
        end else if (active) begin
            if (scl_rise && bit_cnt < 4'd8) begin
                shreg   <= byte_q;
                bit_cnt <= bit_cnt + 4'd1;
                if (bit_cnt == 4'd7) ack_lat <= ack_en;
            end else if (scl_fall && bit_cnt == 4'd8) begin
                if (!in_ack) begin
                    in_ack   <= 1'b1;
                    sda_oe_o <= ack_lat;
                end else begin
                    in_ack   <= 1'b0;
                    sda_oe_o <= 1'b0;
                    bit_cnt  <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/eewr_frame.sv
// Frame sequencer: command byte, identity byte, word address, data bytes.
// Decides each acknowledge and flags the commit at stop.
// Assumes byte_p and the start/stop pulses are never high together.
module eewr_frame
    import eewr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_p,
    input  logic       stop_p,
    input  logic       byte_p,
    input  logic [7:0] byte_q,
    input  logic       busy,
    input  logic       lock,
    input  logic [7:0] local_id,
    output logic       ack_en,
    output logic       addr_p,
    output logic       data_p,
    output logic       commit_p,
    output logic       cmd_lock,
    output logic       out_en_o
);
    frame_st_t st;
    logic      have_data;
    logic      is_wr, is_lock;

    assign is_wr   = (byte_q[7:4] == CMD_TAG) && (byte_q[2:0] == LOW_WRITE);
    assign is_lock = (byte_q[7:4] == CMD_TAG) && (byte_q[2:0] == LOW_LOCK);

    // Acknowledge decision for the byte now completing.
    always_comb begin
        ack_en = 1'b0;
        if (!busy) begin
            case (st)
                FR_CTRL: ack_en = is_wr || (is_lock && !lock);
                FR_ID:   ack_en = (byte_q == local_id);
                FR_ADDR: ack_en = 1'b1;
                FR_DATA: ack_en = 1'b1;
                default: ack_en = 1'b0;
            endcase
        end
    end

    assign addr_p   = byte_p && (st == FR_ADDR) && ack_en;
    assign data_p   = byte_p && (st == FR_DATA) && ack_en;
    assign commit_p = stop_p && (st == FR_DATA) && have_data;

    // Advance through the frame fields; fall into skip on any refusal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= FR_IDLE; have_data <= 1'b0;
            cmd_lock <= 1'b0; out_en_o <= 1'b0;
        end else if (start_p) begin
            st <= FR_CTRL; have_data <= 1'b0;
        end else if (stop_p) begin
            st <= FR_IDLE; have_data <= 1'b0;
        end else if (byte_p) begin
            case (st)
                FR_CTRL: begin
                    if (ack_en) begin
                        out_en_o <= byte_q[3];
                        cmd_lock <= is_lock;
                        st       <= FR_ID;
                    end else begin
                        st <= FR_SKIP;
                    end
                end
                FR_ID:   st <= ack_en ? FR_ADDR : FR_SKIP;
                FR_ADDR: st <= ack_en ? FR_DATA : FR_SKIP;
                FR_DATA: begin
                    if (ack_en) have_data <= 1'b1;
                    else        st <= FR_SKIP;
                end
                default: st <= st;
            endcase
        end
    end
endmodule

// File: rtl/eewr_store.sv
// Page buffer, behavioural array, write-cycle timer and one-time protect bit.
// Assumes commit_p only arrives while the timer is idle.
module eewr_store #(
    parameter int PAGE_BYTES   = 16,
    parameter int MEM_BYTES    = 256,
    parameter int WRITE_CYCLES = 40
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_p,
    input  logic                         addr_p,
    input  logic                         data_p,
    input  logic [7:0]                   byte_q,
    input  logic                         commit_p,
    input  logic                         cmd_lock,
    input  logic                         low_supply,
    input  logic [$clog2(MEM_BYTES)-1:0] rd_addr,
    output logic [7:0]                   rd_data,
    output logic                         busy,
    output logic                         lock
);
    localparam int OFS_W = $clog2(PAGE_BYTES);
    localparam int AW    = $clog2(MEM_BYTES);
    localparam int TW    = $clog2(WRITE_CYCLES + 1);

    logic [7:0]       pbuf [PAGE_BYTES];
    logic [7:0]       mem  [MEM_BYTES];
    logic [PAGE_BYTES-1:0] mask;
    logic [OFS_W-1:0] ptr;
    logic [AW-OFS_W-1:0] page;
    logic [TW-1:0]    tmr;
    logic             prog_ok;

    assign prog_ok = !low_supply;
    assign busy    = (tmr != '0);
    assign rd_data = mem[rd_addr];

    // Track the page, the wrapping offset and which buffer slots hold data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0; ptr <= '0; page <= '0;
        end else if (start_p || commit_p) begin
            mask <= '0;
        end else if (addr_p) begin
            ptr  <= byte_q[OFS_W-1:0];
            page <= byte_q[AW-1:OFS_W];
        end else if (data_p) begin
            mask[ptr] <= 1'b1;
            ptr       <= ptr + 1'b1;
        end
    end

    // Hold incoming data bytes in the page buffer.
    always_ff @(posedge clk) begin
        if (data_p) pbuf[ptr] <= byte_q;
    end

    // Copy filled buffer slots into the array when a permitted commit occurs.
    always_ff @(posedge clk) begin
        for (int i = 0; i < PAGE_BYTES; i++) begin
            if (commit_p && !cmd_lock && !lock && prog_ok && mask[i])
                mem[{page, OFS_W'(i)}] <= pbuf[i];
        end
    end

    // Count down the internal write cycle and program the protect bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr  <= '0;
            lock <= 1'b0;
        end else begin
            if (commit_p)       tmr <= TW'(WRITE_CYCLES);
            else if (tmr != '0) tmr <= tmr - 1'b1;
            if (commit_p && cmd_lock && prog_ok) lock <= 1'b1;
        end
    end
endmodule

// File: rtl/eewr_slave.sv
// Top of the two-wire serial memory write slave.
// Assumes sda_i carries the master's drive; sda_oe_o is the slave's pull-down.
module eewr_slave #(
    parameter int PAGE_BYTES   = 16,
    parameter int MEM_BYTES    = 256,
    parameter int WRITE_CYCLES = 40
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         scl_i,
    input  logic                         sda_i,
    output logic                         sda_oe_o,
    input  logic [7:0]                   local_id_i,
    input  logic                         low_supply_i,
    output logic                         out_en_o,
    output logic                         busy_o,
    output logic                         lock_o,
    input  logic [$clog2(MEM_BYTES)-1:0] rd_addr_i,
    output logic [7:0]                   rd_data_o
);
    logic       start_p, stop_p, byte_p, ack_en;
    logic       addr_p, data_p, commit_p, cmd_lock;
    logic [7:0] byte_q;

    eewr_bus u_bus (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .ack_en(ack_en), .start_p(start_p), .stop_p(stop_p),
        .byte_p(byte_p), .byte_q(byte_q), .sda_oe_o(sda_oe_o)
    );

    eewr_frame u_frame (
        .clk(clk), .rst_n(rst_n), .start_p(start_p), .stop_p(stop_p),
        .byte_p(byte_p), .byte_q(byte_q), .busy(busy_o), .lock(lock_o),
        .local_id(local_id_i), .ack_en(ack_en), .addr_p(addr_p),
        .data_p(data_p), .commit_p(commit_p), .cmd_lock(cmd_lock),
        .out_en_o(out_en_o)
    );

    eewr_store #(
        .PAGE_BYTES(PAGE_BYTES), .MEM_BYTES(MEM_BYTES),
        .WRITE_CYCLES(WRITE_CYCLES)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .start_p(start_p), .addr_p(addr_p),
        .data_p(data_p), .byte_q(byte_q), .commit_p(commit_p),
        .cmd_lock(cmd_lock), .low_supply(low_supply_i),
        .rd_addr(rd_addr_i), .rd_data(rd_data_o),
        .busy(busy_o), .lock(lock_o)
    );
endmodule

// File: rtl/eewr_slave_chk.sv
// Property checker for eewr_slave, attached by bind.
// Assumes the lookup address is quiet whenever array stability is judged.
module eewr_slave_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_i,
    input logic          sda_oe_o,
    input logic          low_supply_i,
    input logic          busy_o,
    input logic          lock_o,
    input logic [AW-1:0] rd_addr_i,
    input logic [7:0]    rd_data_o,
    input logic          stop_p
);
    AST_ACK_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_i); // R2
    AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !sda_oe_o); // R6
    AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(stop_p)); // R6
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |=> lock_o); // R7
    AST_LOCKED_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |=> ($stable(rd_data_o) || !$stable(rd_addr_i))); // R7
    AST_LOW_SUPPLY_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
        low_supply_i |=> ($stable(rd_data_o) || !$stable(rd_addr_i))); // R9
endmodule

bind eewr_slave eewr_slave_chk #(.AW($clog2(MEM_BYTES))) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
    .low_supply_i(low_supply_i), .busy_o(busy_o), .lock_o(lock_o),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .stop_p(stop_p)
);

// File: tb/eewr_slave_bench.sv
// Scoreboard bench: the bus driver queues the expected acknowledge of every
// byte; a monitor pops and compares it in the ninth clock.
module eewr_slave_bench;
    localparam int WC  = 400;
    localparam int P   = 4;
    localparam logic [7:0] MY_ID = 8'h5A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1, sda = 1'b1;
    logic       low = 1'b0;
    logic [7:0] rd_addr = '0;
    logic       sda_oe_o, out_en_o, busy_o, lock_o;
    logic [7:0] rd_data_o;

    int total = 0, bad = 0, busy_run = 0, last_busy = 0;
    bit finished = 0;

    typedef struct { bit exp; string req; } ack_item_t;
    ack_item_t  ack_q[$];
    event       ack_ev;
    logic [7:0] payload[$];

    always #5 clk = ~clk;

    eewr_slave #(.PAGE_BYTES(16), .MEM_BYTES(256), .WRITE_CYCLES(WC)) u_eewr_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_oe_o(sda_oe_o),
        .local_id_i(MY_ID), .low_supply_i(low), .out_en_o(out_en_o),
        .busy_o(busy_o), .lock_o(lock_o), .rd_addr_i(rd_addr), .rd_data_o(rd_data_o)
    );

    function automatic void chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endfunction

    task automatic wt(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda = 1'b1; wt(P); scl = 1'b1; wt(P);
        sda = 1'b0; wt(P); scl = 1'b0; wt(P);
    endtask

    task automatic bus_stop();
        sda = 1'b0; wt(P); scl = 1'b1; wt(P); sda = 1'b1; wt(P);
    endtask

    task automatic send_byte(logic [7:0] b, bit exp_ack, string req);
        for (int i = 7; i >= 0; i--) begin
            sda = b[i]; wt(P); scl = 1'b1; wt(2*P); scl = 1'b0; wt(P);
        end
        sda = 1'b1; wt(P); scl = 1'b1; wt(P);
        ack_q.push_back('{exp_ack, req});
        -> ack_ev;
        wt(P); scl = 1'b0; wt(P);
    endtask

    task automatic frame(logic [7:0] ctl, logic [7:0] idb, logic [7:0] adr,
                         bit a_ctl, bit a_id, bit a_rest, string req);
        bus_start();
        send_byte(ctl, a_ctl, req);
        send_byte(idb, a_id, req);
        send_byte(adr, a_rest, req);
        foreach (payload[i]) send_byte(payload[i], a_rest, req);
        bus_stop();
    endtask

    task automatic wait_idle();
        while (busy_o) wt(1);
        wt(2);
    endtask

    task automatic check_mem(logic [7:0] a, logic [7:0] exp, string req);
        rd_addr = a; wt(1);
        chk(req, rd_data_o, exp);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Monitor: compare the slave's pull-down against the queued expectation.
    initial forever begin
        ack_item_t it;
        @(ack_ev);
        it = ack_q.pop_front();
        chk({it.req, " ack"}, sda_oe_o, it.exp);
    end

    // Measure the length of each busy interval.
    initial forever begin
        @(posedge clk);
        if (busy_o) busy_run++;
        else if (busy_run != 0) begin last_busy = busy_run; busy_run = 0; end
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] page_exp [16];
        wt(4); rst_n = 1'b1; wt(2);
        // R1 reset state
        chk("R1 sda", sda_oe_o, 0);
        chk("R1 busy", busy_o, 0);
        chk("R1 lock", lock_o, 0);
        chk("R1 out_en", out_en_o, 0);

        // R4 byte write, oe=1 command 0x6A
        payload = {8'hA5};
        frame(8'h6A, MY_ID, 8'h23, 1, 1, 1, "R4");
        chk("R6 busy after stop", busy_o, 1);
        // R6 no acknowledge while the cycle runs
        bus_start(); send_byte(8'h6A, 0, "R6"); bus_stop();
        chk("R6 still busy", busy_o, 1);
        wait_idle();
        chk("R6 cycle length", last_busy, WC);
        chk("R2 out_en set", out_en_o, 1);
        check_mem(8'h23, 8'hA5, "R4");

        // R5 page write with wrap, oe=0 command 0x62
        payload = {};
        for (int i = 0; i < 18; i++) payload.push_back(8'(8'h10 + i));
        for (int i = 0; i < 18; i++) page_exp[(5 + i) % 16] = 8'(8'h10 + i);
        frame(8'h62, MY_ID, 8'h45, 1, 1, 1, "R5");
        chk("R2 out_en clear", out_en_o, 0);
        wait_idle();
        for (int k = 0; k < 16; k++) check_mem(8'(8'h40 + k), page_exp[k], "R5");

        // R3 identity mismatch
        payload = {8'h11};
        frame(8'h6A, MY_ID, 8'h60, 1, 1, 1, "R4");
        wait_idle();
        payload = {8'h77};
        frame(8'h6A, 8'hA5, 8'h60, 1, 0, 0, "R3");
        wt(4);
        chk("R3 no cycle", busy_o, 0);
        check_mem(8'h60, 8'h11, "R3");

        // R2 rejected command bytes
        payload = {8'h33};
        frame(8'h6B, MY_ID, 8'h60, 0, 0, 0, "R2");
        frame(8'h7A, MY_ID, 8'h60, 0, 0, 0, "R2");
        wt(4);
        chk("R2 no cycle", busy_o, 0);

        // R10 repeated start and frame without data
        bus_start(); send_byte(8'h6A, 1, "R10");
        payload = {8'h22};
        frame(8'h6A, MY_ID, 8'h61, 1, 1, 1, "R10");
        wait_idle();
        check_mem(8'h61, 8'h22, "R10");
        payload = {};
        frame(8'h6A, MY_ID, 8'h62, 1, 1, 1, "R10");
        wt(4);
        chk("R10 no cycle", busy_o, 0);

        // R9 low supply
        low = 1'b1;
        payload = {8'h99};
        frame(8'h6A, MY_ID, 8'h61, 1, 1, 1, "R9");
        chk("R9 cycle runs", busy_o, 1);
        wait_idle();
        check_mem(8'h61, 8'h22, "R9");
        low = 1'b0;

        // R7 protect command, then writes blocked
        payload = {8'h00};
        frame(8'h60, MY_ID, 8'h23, 1, 1, 1, "R7");
        wait_idle();
        chk("R7 lock set", lock_o, 1);
        check_mem(8'h23, 8'hA5, "R7");
        payload = {8'h00};
        frame(8'h6A, MY_ID, 8'h23, 1, 1, 1, "R7");
        wait_idle();
        check_mem(8'h23, 8'hA5, "R7");
        chk("R2 out_en from latest", out_en_o, 1);

        // R8 protect refused once set
        payload = {8'h00};
        frame(8'h60, MY_ID, 8'h00, 0, 0, 0, "R8");
        wt(4);
        chk("R8 no cycle", busy_o, 0);
        chk("R8 lock kept", lock_o, 1);

        wt(10);
        finish_run();
    end
endmodule